// File: doc/BRIEF.md
# Status Flags and Conditional Skip Unit

This block keeps the three status bits of a small accumulator processor: carry, zero, and a flag that records which of two address-pointer pairs is currently the active one. Carry and zero are captured from the ALU only when an ALU operation reads the accumulator and writes its result back into it. The pointer flag flips each time the pointer-swap instruction executes.

The block also decodes the status opcode group, which is every opcode whose top five bits are `11110`. In that group, opcode bit 1 selects carry, bit 2 selects zero and bit 0 inverts the selected flag. When exactly one flag is selected, the opcode is a conditional skip. The unit then reports a skip bit, which the fetch logic adds to the usual increment, so that the next address is current + 1 + skip. When neither flag or both flags are selected, the opcode is not a skip. Low bits `000` and `110` request a bitwise invert of the accumulator, and `001` and `111` are flagged as illegal. The skip decision always uses the flag values held before the current clock edge. The carry flag is also sent back to the ALU as its carry input.

Top module: `cond_flag_unit`

## Requirements
- R1: With `rst` high at a rising clock edge, carry, zero and pointer flags all read 0 after that edge.
- R2: When `alu_wb_i` is high at an edge, carry and zero take the values of `alu_carry_i` and `alu_zero_i` after that edge.
- R3: When `alu_wb_i` is low, carry and zero keep their values whatever `alu_carry_i` and `alu_zero_i` carry.
- R4: The pointer flag inverts at each edge where `ptr_swap_i` is high and holds otherwise; ALU writeback does not touch it.
- R5: Unless `op_valid_i` is high and `opcode_i[7:3]` equals `11110`, `skip_o`, `inv_acc_o` and `illegal_o` are all 0.
- R6: In the status group, low bits `010` give `skip_o` = carry and `011` give `skip_o` = not carry.
- R7: In the status group, low bits `100` give `skip_o` = zero and `101` give `skip_o` = not zero.
- R8: In the status group, low bits `000` and `110` drive `inv_acc_o` = 1 with `skip_o` = 0 and `illegal_o` = 0.
- R9: In the status group, low bits `001` and `111` drive `illegal_o` = 1 with `skip_o` = 0 and `inv_acc_o` = 0.
- R10: `alu_cin_o` always equals the registered carry flag.
- R11: A skip decision made in the same cycle as an ALU writeback uses the flag values from before that writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alu_wb_i | input | 1 | ALU result from accumulator is written back to accumulator |
| alu_carry_i | input | 1 | Carry produced by the ALU |
| alu_zero_i | input | 1 | Zero produced by the ALU |
| ptr_swap_i | input | 1 | Pointer-swap instruction executes |
| op_valid_i | input | 1 | `opcode_i` holds an executing instruction |
| opcode_i | input | 8 | Current instruction byte |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| shadow_o | output | 1 | Active-pointer flag |
| alu_cin_o | output | 1 | Carry input for add-with-carry and rotate-through-carry |
| skip_o | output | 1 | Extra address increment for a taken skip |
| inv_acc_o | output | 1 | Accumulator invert request |
| illegal_o | output | 1 | Undefined status opcode |

## Verification
The assertions assume that `opcode_i` and `op_valid_i` are stable for the whole cycle and that writeback and swap strobes hold for one cycle at a time. They do not assume that writeback and a status opcode arrive in separate cycles. The stimulus changes every input only at the falling edge, so each strobe lasts exactly one clock. It deliberately overlaps writeback with a skip and swap with an illegal code. It also drives ALU values while writeback is low, and uses a status-pattern byte with the wrong prefix and a valid prefix with `op_valid_i` low.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    typedef struct packed {
        logic carry;
        logic zero;
        logic shadow;
    } flags_t;

    typedef enum logic [1:0] {
        ST_NONE    = 2'd0,
        ST_SKIP    = 2'd1,
        ST_INV_ACC = 2'd2,
        ST_ILLEGAL = 2'd3
    } st_kind_e;

endpackage

// File: rtl/cfu_status_decode.sv
module cfu_status_decode #(
    parameter int                 OPW        = 8,
    parameter int                 PFX_W      = 5,
    parameter logic [PFX_W-1:0]   GRP_PREFIX = 5'b11110
) (
    input  logic                  op_valid_i,
    input  logic [OPW-1:0]        opcode_i,
    output cfu_pkg::st_kind_e     kind_o,
    output logic                  sel_carry_o,
    output logic                  negate_o
);
    import cfu_pkg::*;

    localparam int LOW_W = OPW - PFX_W;

    logic             in_grp;
    logic [LOW_W-1:0] low;

    assign low    = opcode_i[LOW_W-1:0];
    assign in_grp = op_valid_i && (opcode_i[OPW-1:LOW_W] == GRP_PREFIX);

    always_comb begin
        kind_o      = ST_NONE;
        sel_carry_o = low[1];
        negate_o    = low[0];
        if (in_grp) begin
            if (low[1] != low[2]) begin
                kind_o = ST_SKIP;
            end else if (!low[0]) begin
                kind_o = ST_INV_ACC;
            end else begin
                kind_o = ST_ILLEGAL;
            end
        end
    end

endmodule

// File: rtl/cfu_skip_eval.sv
module cfu_skip_eval (
    input  cfu_pkg::flags_t   flags_i,
    input  cfu_pkg::st_kind_e kind_i,
    input  logic              sel_carry_i,
    input  logic              negate_i,
    output logic              skip_o
);
    import cfu_pkg::*;

    logic picked;

    always_comb begin
        picked = sel_carry_i ? flags_i.carry : flags_i.zero;
        skip_o = (kind_i == ST_SKIP) && (picked ^ negate_i);
    end

endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit #(
    parameter int               OPW        = 8,
    parameter int               PFX_W      = 5,
    parameter logic [PFX_W-1:0] GRP_PREFIX = 5'b11110
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           alu_wb_i,
    input  logic           alu_carry_i,
    input  logic           alu_zero_i,
    input  logic           ptr_swap_i,
    input  logic           op_valid_i,
    input  logic [OPW-1:0] opcode_i,
    output logic           carry_o,
    output logic           zero_o,
    output logic           shadow_o,
    output logic           alu_cin_o,
    output logic           skip_o,
    output logic           inv_acc_o,
    output logic           illegal_o
);
    import cfu_pkg::*;

    flags_t    flg_d, flg_q;
    st_kind_e  kind;
    logic      sel_carry;
    logic      negate;

    cfu_status_decode #(
        .OPW        (OPW),
        .PFX_W      (PFX_W),
        .GRP_PREFIX (GRP_PREFIX)
    ) u_dec (
        .op_valid_i  (op_valid_i),
        .opcode_i    (opcode_i),
        .kind_o      (kind),
        .sel_carry_o (sel_carry),
        .negate_o    (negate)
    );

    cfu_skip_eval u_skip (
        .flags_i     (flg_q),
        .kind_i      (kind),
        .sel_carry_i (sel_carry),
        .negate_i    (negate),
        .skip_o      (skip_o)
    );

    always_comb begin
        flg_d = flg_q;
        if (alu_wb_i) begin
            flg_d.carry = alu_carry_i;
            flg_d.zero  = alu_zero_i;
        end
        if (ptr_swap_i) begin
            flg_d.shadow = !flg_q.shadow;
        end
        if (rst) begin
            flg_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        flg_q <= flg_d;
    end

    assign carry_o   = flg_q.carry;
    assign zero_o    = flg_q.zero;
    assign shadow_o  = flg_q.shadow;
    assign alu_cin_o = flg_q.carry;
    assign inv_acc_o = (kind == ST_INV_ACC);
    assign illegal_o = (kind == ST_ILLEGAL);

endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
    parameter int               OPW        = 8,
    parameter int               PFX_W      = 5,
    parameter logic [PFX_W-1:0] GRP_PREFIX = 5'b11110
) (
    input logic           clk,
    input logic           rst,
    input logic           alu_wb_i,
    input logic           alu_carry_i,
    input logic           alu_zero_i,
    input logic           ptr_swap_i,
    input logic           op_valid_i,
    input logic [OPW-1:0] opcode_i,
    input logic           carry_o,
    input logic           zero_o,
    input logic           shadow_o,
    input logic           skip_o,
    input logic           inv_acc_o,
    input logic           illegal_o
);
    localparam int LOW_W = OPW - PFX_W;

    logic in_grp;
    assign in_grp = op_valid_i && (opcode_i[OPW-1:LOW_W] == GRP_PREFIX);

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (!carry_o && !zero_o && !shadow_o)); // R1

    AST_WB_LOAD: assert property (@(posedge clk) disable iff (rst)
        alu_wb_i |=> (carry_o == $past(alu_carry_i)) && (zero_o == $past(alu_zero_i))); // R2

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !alu_wb_i |=> ($stable(carry_o) && $stable(zero_o))); // R3

    AST_SHADOW_FLIP: assert property (@(posedge clk) disable iff (rst)
        ptr_swap_i |=> (shadow_o != $past(shadow_o))); // R4

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ptr_swap_i |=> $stable(shadow_o)); // R4

    AST_GROUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_grp |-> (!skip_o && !inv_acc_o && !illegal_o)); // R5

    AST_SKIP_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_grp && opcode_i[LOW_W-1:0] == 3'b010) |-> (skip_o == carry_o)); // R6

    AST_SKIP_ZERO_CLR: assert property (@(posedge clk) disable iff (rst)
        (in_grp && opcode_i[LOW_W-1:0] == 3'b101) |-> (skip_o == !zero_o)); // R7

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({skip_o, inv_acc_o, illegal_o})); // R8

    AST_ILLEGAL_NOSKIP: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!skip_o && !inv_acc_o)); // R9

endmodule

bind cond_flag_unit cfu_checker #(
    .OPW        (OPW),
    .PFX_W      (PFX_W),
    .GRP_PREFIX (GRP_PREFIX)
) u_cfu_checker (
    .clk         (clk),
    .rst         (rst),
    .alu_wb_i    (alu_wb_i),
    .alu_carry_i (alu_carry_i),
    .alu_zero_i  (alu_zero_i),
    .ptr_swap_i  (ptr_swap_i),
    .op_valid_i  (op_valid_i),
    .opcode_i    (opcode_i),
    .carry_o     (carry_o),
    .zero_o      (zero_o),
    .shadow_o    (shadow_o),
    .skip_o      (skip_o),
    .inv_acc_o   (inv_acc_o),
    .illegal_o   (illegal_o)
);

// File: tb/tb_cond_flag_unit.sv
module tb_cond_flag_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       alu_wb_i, alu_carry_i, alu_zero_i, ptr_swap_i, op_valid_i;
    logic [7:0] opcode_i;
    logic       carry_o, zero_o, shadow_o, alu_cin_o, skip_o, inv_acc_o, illegal_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_flag_unit dut (
        .clk         (clk),
        .rst         (rst),
        .alu_wb_i    (alu_wb_i),
        .alu_carry_i (alu_carry_i),
        .alu_zero_i  (alu_zero_i),
        .ptr_swap_i  (ptr_swap_i),
        .op_valid_i  (op_valid_i),
        .opcode_i    (opcode_i),
        .carry_o     (carry_o),
        .zero_o      (zero_o),
        .shadow_o    (shadow_o),
        .alu_cin_o   (alu_cin_o),
        .skip_o      (skip_o),
        .inv_acc_o   (inv_acc_o),
        .illegal_o   (illegal_o)
    );

    // stimulus, then outputs expected before the edge, then flags expected after it
    typedef struct packed {
        logic       wb, ac, az, sw, val;
        logic [7:0] op;
        logic       skip, inv, ill;
        logic       c, z, s;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF2, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R6 carry clear
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF3, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R6
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF4, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R7
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF5, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R7
        '{1'b1,1'b1,1'b0,1'b0,1'b1,8'hF2, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R11 old carry used
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF2, 1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R6 carry set
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF3, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R6
        '{1'b1,1'b0,1'b1,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R2 R5
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF4, 1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R7 zero set
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF5, 1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R7
        '{1'b0,1'b0,1'b0,1'b1,1'b1,8'hF0, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1}, // R8 R4
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF6, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1}, // R8
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF1, 1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1}, // R9
        '{1'b0,1'b0,1'b0,1'b1,1'b1,8'hF7, 1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0}, // R9 R4
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'hF2, 1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R3 R5 not valid
        '{1'b1,1'b1,1'b1,1'b1,1'b1,8'hE2, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1}, // R5 wrong prefix
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'hF3, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1}, // R6
        '{1'b1,1'b0,1'b0,1'b0,1'b1,8'hF4, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1}  // R7 R11
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_idle();
        alu_wb_i = 0; alu_carry_i = 0; alu_zero_i = 0;
        ptr_swap_i = 0; op_valid_i = 0; opcode_i = 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive_idle();
        alu_wb_i = 1; alu_carry_i = 1; alu_zero_i = 1; ptr_swap_i = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset flags", {5'b0, carry_o, zero_o, shadow_o}, 8'h00);
        rst = 1'b0;
        drive_idle();

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            alu_wb_i = VECS[i].wb; alu_carry_i = VECS[i].ac; alu_zero_i = VECS[i].az;
            ptr_swap_i = VECS[i].sw; op_valid_i = VECS[i].val; opcode_i = VECS[i].op;
            #1;
            chk("R6 R7 R11 skip", {7'b0, skip_o}, {7'b0, VECS[i].skip});
            chk("R8 inv_acc", {7'b0, inv_acc_o}, {7'b0, VECS[i].inv});
            chk("R9 illegal", {7'b0, illegal_o}, {7'b0, VECS[i].ill});
            @(posedge clk);
            #1;
            chk("R2 R3 R4 flags", {5'b0, carry_o, zero_o, shadow_o},
                {5'b0, VECS[i].c, VECS[i].z, VECS[i].s});
            chk("R10 alu carry in", {7'b0, alu_cin_o}, {7'b0, VECS[i].c});
        end

        // flags now carry=0 zero=0 shadow=1; set carry and zero, then reset mid-run
        @(negedge clk);
        drive_idle();
        alu_wb_i = 1; alu_carry_i = 1; alu_zero_i = 1;
        @(negedge clk);
        chk("R2 set both", {5'b0, carry_o, zero_o, shadow_o}, 8'h07);
        chk("R10 carry in high", {7'b0, alu_cin_o}, 8'h01);
        drive_idle();
        rst = 1'b1;
        ptr_swap_i = 1; alu_wb_i = 1; alu_carry_i = 1; alu_zero_i = 1;
        @(negedge clk);
        chk("R1 reset overrides strobes", {5'b0, carry_o, zero_o, shadow_o}, 8'h00);
        rst = 1'b0;
        drive_idle();
        // R3: ALU values without writeback are ignored
        alu_carry_i = 1; alu_zero_i = 1;
        @(negedge clk);
        chk("R3 no writeback", {6'b0, carry_o, zero_o}, 8'h00);
        // R4: two swaps return the pointer flag
        ptr_swap_i = 1;
        @(negedge clk);
        chk("R4 first swap", {7'b0, shadow_o}, 8'h01);
        @(negedge clk);
        chk("R4 second swap", {7'b0, shadow_o}, 8'h00);
        drive_idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule